// File: doc/BRIEF.md
# Complex Rounding-Doubling Multiply-Accumulate Unit

This unit performs one step of complex multiply-accumulate on a vector of signed integers held as interleaved complex numbers. The vector is cut into 128-bit segments. Within each segment, one complex coefficient is chosen by an index. Every complex pair of the multiplicand then contributes a single component, real or imaginary as the rotation code picks. That component is multiplied by the coefficient at full precision, doubled, and added to or subtracted from the matching accumulator element raised by the element width. The sum is rounded, its high half is kept, and that half is saturated back to the element width.

The multiplication is never clamped; only the final result is. Two operations on the same operands with rotation codes 90 degrees apart build a full complex multiply-add or multiply-subtract. Elements are 16 or 32 bits wide, chosen per operation. A result vector and a per-element clamp flag vector are registered one cycle after the input strobe, and every element is written.

Top module: `cplx_rdmac`

## Requirements
- R1: `outValid` is high in exactly the cycle after a cycle with `inValid` high, and low otherwise. Reset (`rstN` low) clears `outValid`, `resVec` and `satFlags` to zero.
- R2: While `inValid` is low, `resVec` and `satFlags` keep their values whatever the other inputs do.
- R3: Each complex pair p occupies elements 2p (real) and 2p+1 (imaginary). The multiplicand component used is element 2p+rotCode[0]. The real result is sat(((acc[2p] << W) ± 2·mult[2p+rotCode[0]]·coef[2s+rotCode[0]] + 2^(W-1)) >>> W), computed at full precision, where W is the element width.
- R4: The imaginary result uses the same multiplicand component, times coefficient element 2s+1−rotCode[0], added to or subtracted from acc[2p+1] in the same way.
- R5: The real lane subtracts when rotCode[0] differs from rotCode[1], and adds otherwise. The imaginary lane subtracts when rotCode[1] is 1, and adds otherwise.
- R6: The coefficient pair s for pair p is the segment's first pair plus the index. With 16-bit elements a segment holds 4 pairs and `coefIdx` (0..3) is used whole. With 32-bit elements a segment holds 2 pairs, only `coefIdx[0]` is used, and `coefIdx[1]` has no effect.
- R7: Rounding is round-half-up (add 2^(W-1), then arithmetic shift right). The shifted value clamps to the range −2^(W-1) to 2^(W-1)−1, and the product itself is never clamped.
- R8: `satFlags` bit k is set when element k of the result was clamped. In 32-bit mode, bits VEC_BITS/32 and above are zero.
- R9: `elemSel` = 0 selects 16-bit elements, and `elemSel` = 1 selects 32-bit elements. Element k occupies bits [k·W +: W] of each vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Operation strobe |
| elemSel | input | 1 | 0: 16-bit elements, 1: 32-bit elements |
| rotCode | input | 2 | Rotation code (0, 90, 180, 270 degrees) |
| coefIdx | input | 2 | Coefficient pair index within each 128-bit segment |
| multVec | input | VEC_BITS | Multiplicand vector |
| coefVec | input | VEC_BITS | Coefficient vector |
| accVec | input | VEC_BITS | Accumulator vector |
| outValid | output | 1 | Result valid |
| resVec | output | VEC_BITS | Result vector |
| satFlags | output | VEC_BITS/16 | Per-element clamp flags |

## Verification
The bench builds the unit with the default VEC_BITS of 256. That gives two 128-bit segments, so the per-segment coefficient selection is exercised across a segment boundary in both element widths. It gives 8 pairs at 16 bits and 4 pairs at 32 bits, so saturation flags are seen both in the lower half and in the upper half that stays zero in 32-bit mode. Random operands biased toward the extreme values reach both clamp directions. They also reach the case of minimum times minimum, where only an unclamped product gives the right answer.

// File: rtl/cplx_rdmac_pkg.sv
package cplx_rdmac_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic load;     // capture results this cycle
    logic mode32;   // 32-bit elements
    logic pickOdd;  // multiplicand component / real-product coefficient parity
    logic subRe;    // real lane subtracts
    logic subIm;    // imaginary lane subtracts
  } rdmacStrobes_t;

  typedef enum logic {ELEM16 = 1'b0, ELEM32 = 1'b1} elemWidth_e;
endpackage

// File: rtl/cplx_rdmac_lane.sv
module cplx_rdmac_lane #(
  parameter int W = 16
) (
  input  logic signed [W-1:0] opA,
  input  logic signed [W-1:0] coef,
  input  logic signed [W-1:0] acc,
  input  logic                sub,
  output logic        [W-1:0] res,
  output logic                sat
);
  localparam int SW = 2*W + 3;
  localparam int HW = W + 3;

  logic signed [2*W-1:0] prod;
  logic signed [SW-1:0]  accWide, dblWide, roundK, sumWide;
  logic        [HW-1:0]  hiPart;
  logic                  fits;

  always_comb begin
    prod    = opA * coef;
    accWide = {{3{acc[W-1]}}, acc, {W{1'b0}}};
    dblWide = {{2{prod[2*W-1]}}, prod, 1'b0};
    roundK  = {{HW{1'b0}}, 1'b1, {(W-1){1'b0}}};
    sumWide = (sub ? (accWide - dblWide) : (accWide + dblWide)) + roundK;
    hiPart  = sumWide[SW-1:W];
    fits    = (hiPart[HW-1:W-1] == '0) || (hiPart[HW-1:W-1] == '1);
    sat     = !fits;
    if (fits)               res = hiPart[W-1:0];
    else if (hiPart[HW-1])  res = {1'b1, {(W-1){1'b0}}};
    else                    res = {1'b0, {(W-1){1'b1}}};
  end
endmodule

// File: rtl/cplx_rdmac_ctrl.sv
module cplx_rdmac_ctrl
  import cplx_rdmac_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          inValid,
  input  logic          elemSel,
  input  logic [1:0]    rotCode,
  output rdmacStrobes_t strobes,
  output logic          outValid
);
  always_comb begin
    strobes.load    = inValid;
    strobes.mode32  = (elemWidth_e'(elemSel) == ELEM32);
    strobes.pickOdd = rotCode[0];
    strobes.subRe   = rotCode[0] ^ rotCode[1];
    strobes.subIm   = rotCode[1];
  end

  always_ff @(posedge clk) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end
endmodule

// File: rtl/cplx_rdmac_datapath.sv
module cplx_rdmac_datapath
  import cplx_rdmac_pkg::*;
#(
  parameter int VEC_BITS = 256
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  rdmacStrobes_t         strobes,
  input  logic [1:0]            coefIdx,
  input  logic [VEC_BITS-1:0]   multVec,
  input  logic [VEC_BITS-1:0]   coefVec,
  input  logic [VEC_BITS-1:0]   accVec,
  output logic [VEC_BITS-1:0]   resVec,
  output logic [VEC_BITS/16-1:0] satFlags
);
  localparam int SEG_BITS = 128;
  localparam int E16   = VEC_BITS / 16;
  localparam int E32   = VEC_BITS / 32;
  localparam int P16   = E16 / 2;
  localparam int P32   = E32 / 2;
  localparam int PPS16 = SEG_BITS / 32;
  localparam int PPS32 = SEG_BITS / 64;

  logic [VEC_BITS-1:0] comb16, comb32;
  logic [E16-1:0]      sat16;
  logic [E32-1:0]      sat32;

  genvar p;
  generate
    for (p = 0; p < P16; p++) begin : g16
      logic [15:0] opA, cRe, cIm;
      always_comb begin
        int s;
        s   = (p / PPS16) * PPS16 + int'(coefIdx);
        opA = multVec[(2*p + int'(strobes.pickOdd))*16 +: 16];
        cRe = coefVec[(2*s + int'(strobes.pickOdd))*16 +: 16];
        cIm = coefVec[(2*s + int'(!strobes.pickOdd))*16 +: 16];
      end
      cplx_rdmac_lane #(.W(16)) uRe (
        .opA(opA), .coef(cRe), .acc(accVec[(2*p)*16 +: 16]), .sub(strobes.subRe),
        .res(comb16[(2*p)*16 +: 16]), .sat(sat16[2*p]));
      cplx_rdmac_lane #(.W(16)) uIm (
        .opA(opA), .coef(cIm), .acc(accVec[(2*p+1)*16 +: 16]), .sub(strobes.subIm),
        .res(comb16[(2*p+1)*16 +: 16]), .sat(sat16[2*p+1]));
    end

    for (p = 0; p < P32; p++) begin : g32
      logic [31:0] opA, cRe, cIm;
      always_comb begin
        int s;
        s   = (p / PPS32) * PPS32 + int'(coefIdx[0]);
        opA = multVec[(2*p + int'(strobes.pickOdd))*32 +: 32];
        cRe = coefVec[(2*s + int'(strobes.pickOdd))*32 +: 32];
        cIm = coefVec[(2*s + int'(!strobes.pickOdd))*32 +: 32];
      end
      cplx_rdmac_lane #(.W(32)) uRe (
        .opA(opA), .coef(cRe), .acc(accVec[(2*p)*32 +: 32]), .sub(strobes.subRe),
        .res(comb32[(2*p)*32 +: 32]), .sat(sat32[2*p]));
      cplx_rdmac_lane #(.W(32)) uIm (
        .opA(opA), .coef(cIm), .acc(accVec[(2*p+1)*32 +: 32]), .sub(strobes.subIm),
        .res(comb32[(2*p+1)*32 +: 32]), .sat(sat32[2*p+1]));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resVec   <= '0;
      satFlags <= '0;
    end else if (strobes.load) begin
      resVec   <= strobes.mode32 ? comb32 : comb16;
      satFlags <= strobes.mode32 ? E16'(sat32) : sat16;
    end
  end
endmodule

// File: rtl/cplx_rdmac.sv
module cplx_rdmac
  import cplx_rdmac_pkg::*;
#(
  parameter int VEC_BITS = 256
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   inValid,
  input  logic                   elemSel,
  input  logic [1:0]             rotCode,
  input  logic [1:0]             coefIdx,
  input  logic [VEC_BITS-1:0]    multVec,
  input  logic [VEC_BITS-1:0]    coefVec,
  input  logic [VEC_BITS-1:0]    accVec,
  output logic                   outValid,
  output logic [VEC_BITS-1:0]    resVec,
  output logic [VEC_BITS/16-1:0] satFlags
);
  rdmacStrobes_t strobes;

  cplx_rdmac_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .elemSel(elemSel),
    .rotCode(rotCode), .strobes(strobes), .outValid(outValid));

  cplx_rdmac_datapath #(.VEC_BITS(VEC_BITS)) uDp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .coefIdx(coefIdx),
    .multVec(multVec), .coefVec(coefVec), .accVec(accVec),
    .resVec(resVec), .satFlags(satFlags));
endmodule

// File: rtl/cplx_rdmac_checker.sv
module cplx_rdmac_checker #(
  parameter int VEC_BITS = 256
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   inValid,
  input logic                   elemSel,
  input logic                   outValid,
  input logic [VEC_BITS-1:0]    resVec,
  input logic [VEC_BITS/16-1:0] satFlags
);
  localparam int E16 = VEC_BITS / 16;
  localparam int E32 = VEC_BITS / 32;

  logic lastMode32;
  always_ff @(posedge clk) begin
    if (!rstN)        lastMode32 <= 1'b0;
    else if (inValid) lastMode32 <= elemSel;
  end

  a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  a_r1_valid_drops: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);
  a_r2_hold: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> ($stable(resVec) && $stable(satFlags)));
  a_r8_upper_flags_zero: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && lastMode32) |-> (satFlags[E16-1:E32] == '0));
  a_r7_clamp_value: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !lastMode32 && satFlags[0]) |->
      (resVec[15:0] == 16'h7fff || resVec[15:0] == 16'h8000));
endmodule

bind cplx_rdmac cplx_rdmac_checker #(.VEC_BITS(VEC_BITS)) uChk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .elemSel(elemSel),
  .outValid(outValid), .resVec(resVec), .satFlags(satFlags));

// File: tb/cplx_rdmac_test.sv
`timescale 1ns/1ps
module cplx_rdmac_test;
  localparam int VB  = 256;
  localparam int NF  = VB / 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic elemSel = 1'b0;
  logic [1:0] rotCode = '0, coefIdx = '0;
  logic [VB-1:0] multVec = '0, coefVec = '0, accVec = '0;
  logic outValid;
  logic [VB-1:0] resVec;
  logic [NF-1:0] satFlags;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;  // 125 MHz

  cplx_rdmac #(.VEC_BITS(VB)) uut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .elemSel(elemSel),
    .rotCode(rotCode), .coefIdx(coefIdx), .multVec(multVec),
    .coefVec(coefVec), .accVec(accVec), .outValid(outValid),
    .resVec(resVec), .satFlags(satFlags));

  function automatic logic signed [95:0] getE(logic [VB-1:0] v, int k, bit m32);
    logic signed [31:0] t32;
    logic signed [15:0] t16;
    if (m32) begin t32 = v[k*32 +: 32]; return t32; end
    else     begin t16 = v[k*16 +: 16]; return t16; end
  endfunction

  function automatic void laneModel(logic signed [95:0] acc, logic signed [95:0] prod,
      bit sub, int w, output logic [31:0] val, output bit s);
    logic signed [95:0] sum, q, lim;
    sum = (acc <<< w) + (sub ? -(prod <<< 1) : (prod <<< 1)) + (96'sd1 <<< (w-1));
    q   = sum >>> w;
    lim = 96'sd1 <<< (w-1);
    s = 1'b0;
    if (q > lim - 1) begin q = lim - 1; s = 1'b1; end
    else if (q < -lim) begin q = -lim; s = 1'b1; end
    val = q[31:0];
  endfunction

  function automatic void model(logic [VB-1:0] m, c, a, logic [1:0] rot,
      logic [1:0] idx, bit m32, output logic [VB-1:0] r, output logic [NF-1:0] sf);
    int w, pps, pairs, s, sel;
    logic signed [95:0] ea, pr, pi;
    logic [31:0] vR, vI;
    bit sR, sI;
    w = m32 ? 32 : 16;
    pps = 128 / (2*w);
    pairs = VB / (2*w);
    sel = rot[0];
    r = '0; sf = '0;
    for (int p = 0; p < pairs; p++) begin
      s  = p - (p % pps) + (m32 ? int'(idx[0]) : int'(idx));
      ea = getE(m, 2*p + sel, m32);
      pr = ea * getE(c, 2*s + sel, m32);
      pi = ea * getE(c, 2*s + 1 - sel, m32);
      laneModel(getE(a, 2*p, m32),   pr, rot[0] != rot[1], w, vR, sR);
      laneModel(getE(a, 2*p+1, m32), pi, rot[1] == 1'b1,   w, vI, sI);
      if (m32) begin r[(2*p)*32 +: 32] = vR; r[(2*p+1)*32 +: 32] = vI; end
      else begin r[(2*p)*16 +: 16] = vR[15:0]; r[(2*p+1)*16 +: 16] = vI[15:0]; end
      sf[2*p] = sR; sf[2*p+1] = sI;
    end
  endfunction

  function automatic logic [VB-1:0] randVec();
    logic [VB-1:0] v;
    for (int k = 0; k < VB/16; k++) begin
      case ($urandom % 6)
        0: v[k*16 +: 16] = 16'h8000;
        1: v[k*16 +: 16] = 16'h7fff;
        2: v[k*16 +: 16] = 16'h0000;
        default: v[k*16 +: 16] = 16'($urandom);
      endcase
    end
    return v;
  endfunction

  task automatic chk(bit ok, string req, logic [VB-1:0] act, logic [VB-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic runOp(logic [VB-1:0] m, c, a, logic [1:0] rot, logic [1:0] idx,
                       bit m32, string req);
    logic [VB-1:0] er;
    logic [NF-1:0] es;
    model(m, c, a, rot, idx, m32, er, es);
    @(negedge clk);
    multVec = m; coefVec = c; accVec = a; rotCode = rot; coefIdx = idx;
    elemSel = m32; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    chk(outValid === 1'b1, "R1 valid", VB'(outValid), VB'(1));
    chk(resVec === er, req, resVec, er);
    chk(satFlags === es, {req, " flags R8"}, VB'(satFlags), VB'(es));
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [VB-1:0] m, c, a, keep;
    logic [NF-1:0] keepF;
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    chk(outValid === 1'b0 && resVec === '0 && satFlags === '0,
        "R1 reset state", resVec, '0);
    rstN = 1'b1;
    @(negedge clk);

    // Directed: small pattern, all rotations, 16-bit (R3 R4 R5 R9)
    for (int k = 0; k < VB/16; k++) begin
      m[k*16 +: 16] = 16'(100 * (k + 1));
      c[k*16 +: 16] = 16'(-50 * (k + 3));
      a[k*16 +: 16] = 16'(k * 7 - 20);
    end
    for (int r = 0; r < 4; r++) runOp(m, c, a, 2'(r), 2'(r), 1'b0, "R3 R4 R5 R9 rotation 16-bit");

    // Rounding tie: 2*128*128 = 2^15 -> +2^15 -> 1 (R7)
    m = '0; c = '0; a = '0;
    m[15:0] = 16'd128; c[15:0] = 16'd128;
    runOp(m, c, a, 2'd0, 2'd0, 1'b0, "R7 rounding tie");
    chk(resVec[15:0] === 16'd1, "R7 round half up", VB'(resVec[15:0]), VB'(1));

    // Positive saturation of min*min (R7 R8)
    m = {NF{16'h8000}}; c = {NF{16'h8000}}; a = '0;
    runOp(m, c, a, 2'd0, 2'd0, 1'b0, "R7 positive clamp");
    chk(resVec[15:0] === 16'h7fff && satFlags[0] === 1'b1, "R7 R8 clamp high",
        VB'(resVec[15:0]), VB'(16'h7fff));
    // Negative saturation: rotation 2 subtracts in real lane
    a = {NF{16'h8000}};
    runOp(m, c, a, 2'd2, 2'd0, 1'b0, "R7 negative clamp");
    chk(resVec[15:0] === 16'h8000, "R7 clamp low", VB'(resVec[15:0]), VB'(16'h8000));

    // 32-bit mode, index bit 1 ignored (R6 R9)
    m = randVec(); c = randVec(); a = randVec();
    runOp(m, c, a, 2'd1, 2'd1, 1'b1, "R6 R9 32-bit idx1");
    keep = resVec;
    runOp(m, c, a, 2'd1, 2'd3, 1'b1, "R6 32-bit idx3");
    chk(resVec === keep, "R6 coefIdx[1] no effect", resVec, keep);
    m = {8{32'h80000000}}; c = {8{32'h80000000}}; a = '0;
    runOp(m, c, a, 2'd0, 2'd0, 1'b1, "R7 R8 32-bit clamp");

    // Hold while idle (R1 R2)
    keep = resVec; keepF = satFlags;
    @(negedge clk);
    multVec = randVec(); coefVec = randVec(); accVec = randVec(); rotCode = 2'd3;
    elemSel = 1'b0;
    @(negedge clk);
    chk(outValid === 1'b0, "R1 valid low when idle", VB'(outValid), '0);
    chk(resVec === keep && satFlags === keepF, "R2 hold", resVec, keep);

    // Random ops
    for (int n = 0; n < 300; n++)
      runOp(randVec(), randVec(), randVec(), 2'($urandom), 2'($urandom),
            1'($urandom), "R3 R4 R5 R6 R7 random");

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule